// File: doc/BRIEF.md
# Byte-Lane Multiplexed-Address DRAM Device Model

This block is a synthesizable, cycle-sampled functional model of an asynchronous-strobe DRAM with two byte lanes. A fast system clock samples the active-low row strobe, one column strobe per byte lane, the write strobe and the output strobe. The block decodes these into standby, word or byte reads, word or byte writes (early or late), RAS-only refresh and CAS-before-RAS refresh. The row address is taken from the shared address pins when the row strobe falls, and the column address when the combined column strobe falls. A small parameterised array holds the data. Lane data leaves on `dq_out`, and `dq_oe` gives one output enable per lane. A low `dq_oe` bit stands for a high-impedance lane.

A controller under test connects to the block in place of a real device. Holding the row strobe low while the column strobes cycle gives page-mode accesses within the open row. A refresh with the column strobe set up before the row strobe uses an internal 9-bit row counter. The model raises a one-cycle `proto_err` pulse when it sees one of two strobe-ordering faults that it checks for. Timing margins and cell decay are not modelled.

Top module: `bytelane_dram`

## Requirements
- R1: After reset, and whenever the row strobe and both column strobes are high, both bits of `dq_oe` are 0 (both lanes float).
- R2: The combined column strobe becomes active when the first lane strobe falls and inactive only when both are high again. The column is latched only when the combined strobe becomes active. A second lane strobe falling, or one lane strobe rising, while the other stays low does not change the column.
- R3: During a read in an open row, with write high and output-enable low, `dq_oe[0]` equals the inverse of `cas_n[0]` and drives `dq_out[7:0]`. `dq_oe[1]` equals the inverse of `cas_n[1]` and drives `dq_out[15:8]`. The enables take effect from the cycle after the combined column strobe falls.
- R4: A lane is written in the cycle where the later of its own column-strobe fall and the write-strobe fall occurs, with both low. This covers early, late and lane-staggered writes. Only lanes whose strobe is low are stored. The word is addressed by the current row and the latched column.
- R5: A row-strobe fall with both column strobes high, followed by no column activity, is a RAS-only refresh. The outputs float and stored data is unchanged.
- R6: A row-strobe fall while either column strobe is already low is a CAS-before-RAS refresh. The internal 9-bit refresh counter advances by 1 modulo 512. The address pins are ignored. Until the row strobe rises, the outputs float and the write strobe stores nothing.
- R7: With `oe_n` high, or `we_n` low, both lanes float. Raising `oe_n` while a column strobe stays low floats the lane from that cycle on.
- R8: Keeping the row strobe low and cycling the combined column strobe gives page-mode accesses. Each fall latches a new column in the same open row.
- R9: A combined column-strobe fall while the row strobe is high and `we_n` is low is a protocol error. `proto_err` is 1 for the one cycle after the offending edge.
- R10: An early write is a write with `we_n` already low when the combined column strobe fell. If `we_n` changes while an early write is still in progress, `proto_err` is 1 for one cycle.
- R11: The array word index is the low ROW_IDX_W bits of the row followed by the low COL_IDX_W bits of the column. Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Column strobes per lane, active low; bit 0 lower byte, bit 1 upper byte |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data, lane 0 in bits 7:0 |
| dq_out | output | 16 | Read data, lane 0 in bits 7:0 |
| dq_oe | output | 2 | Per-lane output enable (0 = high impedance) |
| proto_err | output | 1 | One-cycle protocol-error pulse |

## Verification
The bench builds the block with ROW_IDX_W = 3 and COL_IDX_W = 3, which gives a 64-word array. At that size, page-mode writes can fill every word and reads can return all of them under rotating lane masks. A full-word pattern computed from the row and column is held in a bench model that byte writes update. The small index widths also make aliasing of the upper address bits reachable. Because of that, rows 1 and 9 must hit the same words. Targeted sequences cover lane-staggered and late writes, strobe overlap in the combined column function, output-strobe withdrawal, both refresh types and both protocol errors.

// File: rtl/bytelane_dram_pkg.sv
`timescale 1ns/1ps
package bytelane_dram_pkg;
  // Access state of the device model
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,  // row strobe high
    MODE_ROW  = 2'd1,  // row open for read/write/RAS-only refresh
    MODE_CBR  = 2'd2   // column-before-row refresh in progress
  } dram_mode_e;
endpackage

// File: rtl/bl_rst_sync.sv
`timescale 1ns/1ps
module bl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_s_n <= meta_q;
    end
  end
endmodule

// File: rtl/bl_strobe_edges.sv
`timescale 1ns/1ps
module bl_strobe_edges #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  output logic             ras_fall,
  output logic             cas_act,
  output logic             cas_fall,
  output logic [LANES-1:0] lane_fall,
  output logic             we_fall,
  output logic             we_chg
);
  logic             ras_p;
  logic [LANES-1:0] cas_p;
  logic             we_p;
  logic             cas_act_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cas_p <= '1;
      we_p  <= 1'b1;
    end else begin
      ras_p <= ras_n;
      cas_p <= cas_n;
      we_p  <= we_n;
    end
  end

  // Combined strobe: active from first lane low to last lane high
  assign cas_act   = ~(&cas_n);
  assign cas_act_p = ~(&cas_p);
  assign cas_fall  = cas_act & ~cas_act_p;
  assign ras_fall  = ras_p & ~ras_n;
  assign lane_fall = cas_p & ~cas_n;
  assign we_fall   = we_p & ~we_n;
  assign we_chg    = we_p ^ we_n;
endmodule

// File: rtl/bl_cmd_decode.sv
`timescale 1ns/1ps
module bl_cmd_decode
  import bytelane_dram_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3,
  parameter int LANES     = 2,
  localparam int IDX_W    = ROW_IDX_W + COL_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic             ras_fall,
  input  logic             cas_act,
  input  logic             cas_fall,
  input  logic [LANES-1:0] lane_fall,
  input  logic             we_fall,
  input  logic             we_chg,
  output dram_mode_e       mode_o,
  output logic [ADDR_W-1:0] refresh_cnt_o,
  output logic [LANES-1:0] wr_lane_o,
  output logic [LANES-1:0] rd_oe_o,
  output logic [IDX_W-1:0] index_o,
  output logic             proto_err_o
);
  dram_mode_e           mode_q, mode_d;
  logic [ROW_IDX_W-1:0] row_q, row_d;
  logic [COL_IDX_W-1:0] col_q, col_d, col_eff;
  logic [ADDR_W-1:0]    rcnt_q, rcnt_d;
  logic                 col_vld_q, col_vld_d;
  logic                 ew_q, ew_d;
  logic                 err_q, err_d;
  logic                 row_en, col_en, rcnt_en;
  logic                 in_row, open_col;
  logic                 unused_addr_hi;

  assign unused_addr_hi = ^addr;

  assign in_row   = (mode_q == MODE_ROW) & ~ras_n;
  assign open_col = in_row & cas_fall;
  assign col_eff  = open_col ? addr[COL_IDX_W-1:0] : col_q;

  always_comb begin
    mode_d = mode_q;
    if (ras_n)         mode_d = MODE_IDLE;
    else if (ras_fall) mode_d = cas_act ? MODE_CBR : MODE_ROW;
    row_en    = ras_fall & ~cas_act;
    row_d     = addr[ROW_IDX_W-1:0];
    rcnt_en   = ras_fall & cas_act;
    rcnt_d    = rcnt_q + 1'b1;
    col_en    = open_col;
    col_d     = addr[COL_IDX_W-1:0];
    col_vld_d = open_col | (col_vld_q & cas_act & in_row);
    ew_d      = (open_col & ~we_n) | (ew_q & cas_act & in_row);
    err_d     = (ras_n & cas_fall & ~we_n) | (ew_q & cas_act & in_row & we_chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      rcnt_q    <= '0;
      col_vld_q <= 1'b0;
      ew_q      <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      if (row_en)  row_q  <= row_d;
      if (col_en)  col_q  <= col_d;
      if (rcnt_en) rcnt_q <= rcnt_d;
      col_vld_q <= col_vld_d;
      ew_q      <= ew_d;
      err_q     <= err_d;
    end
  end

  // Lane write on the later of its own strobe fall and the write fall
  assign wr_lane_o = {LANES{in_row & ~we_n & (col_vld_q | cas_fall)}} & ~cas_n
                   & (lane_fall | {LANES{we_fall}});
  assign rd_oe_o   = {LANES{in_row & col_vld_q & we_n & ~oe_n}} & ~cas_n;
  assign index_o   = {row_q, col_eff};
  assign mode_o        = mode_q;
  assign refresh_cnt_o = rcnt_q;
  assign proto_err_o   = err_q;
endmodule

// File: rtl/bl_lane_array.sv
`timescale 1ns/1ps
module bl_lane_array #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 6,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [IDX_W-1:0]  index,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_lane[g]) mem[index] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[index];
  end
endmodule

// File: rtl/bytelane_dram.sv
`timescale 1ns/1ps
module bytelane_dram
  import bytelane_dram_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3,
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  localparam int IDX_W    = ROW_IDX_W + COL_IDX_W,
  localparam int DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [LANES-1:0]  cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe,
  output logic              proto_err
);
  logic              rst_s_n;
  logic              ras_fall, cas_act, cas_fall, we_fall, we_chg;
  logic [LANES-1:0]  lane_fall;
  dram_mode_e        mode;
  logic [ADDR_W-1:0] refresh_cnt;
  logic [LANES-1:0]  wr_lane;
  logic [IDX_W-1:0]  index;

  bl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  bl_strobe_edges #(.LANES(LANES)) u_edges (
    .clk(clk), .rst_n(rst_s_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ras_fall(ras_fall), .cas_act(cas_act), .cas_fall(cas_fall),
    .lane_fall(lane_fall), .we_fall(we_fall), .we_chg(we_chg)
  );

  bl_cmd_decode #(
    .ADDR_W(ADDR_W), .ROW_IDX_W(ROW_IDX_W), .COL_IDX_W(COL_IDX_W), .LANES(LANES)
  ) u_dec (
    .clk(clk), .rst_n(rst_s_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .ras_fall(ras_fall), .cas_act(cas_act),
    .cas_fall(cas_fall), .lane_fall(lane_fall), .we_fall(we_fall),
    .we_chg(we_chg), .mode_o(mode), .refresh_cnt_o(refresh_cnt),
    .wr_lane_o(wr_lane), .rd_oe_o(dq_oe), .index_o(index),
    .proto_err_o(proto_err)
  );

  bl_lane_array #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .wr_lane(wr_lane), .index(index), .wdata(dq_in), .rdata(dq_out)
  );
endmodule

// File: rtl/bytelane_dram_chk.sv
`timescale 1ns/1ps
module bytelane_dram_chk
  import bytelane_dram_pkg::*;
#(
  parameter int LANES = 2,
  parameter int REF_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [LANES-1:0] dq_oe,
  input dram_mode_e       mode,
  input logic [REF_W-1:0] refresh_cnt,
  input logic [LANES-1:0] wr_lane
);
  AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && (&cas_n)) |-> (dq_oe == '0)); // R1

  AST_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe) |-> ((dq_oe & cas_n) == '0)); // R3

  AST_OUTPUT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !we_n) |-> (dq_oe == '0)); // R7

  AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !(&cas_n)) |=> (refresh_cnt == REF_W'($past(refresh_cnt) + 1'b1))); // R6

  AST_CBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CBR) |-> (dq_oe == '0 && wr_lane == '0)); // R6

  AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |-> (wr_lane == '0)); // R5
endmodule

bind bytelane_dram bytelane_dram_chk #(.LANES(LANES), .REF_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .mode(mode), .refresh_cnt(refresh_cnt),
  .wr_lane(wr_lane)
);

// File: tb/bytelane_dram_bench.sv
`timescale 1ns/1ps
module bytelane_dram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, we_n, oe_n;
  logic [1:0]  cas_n;
  logic [8:0]  addr;
  logic [15:0] dq_in, dq_out;
  logic [1:0]  dq_oe;
  logic        proto_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [64];

  always #4 clk = ~clk;

  bytelane_dram #(.ADDR_W(9), .ROW_IDX_W(3), .COL_IDX_W(3), .LANES(2), .LANE_W(8))
    u_bytelane_dram (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .proto_err(proto_err));

  function automatic logic [15:0] pat(input int r, input int c);
    int n;
    n = r * 8 + c;
    return {8'(n * 7 + 3), 8'(n ^ 8'h5A)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    ras_n = 1'b1; cas_n = 2'b11; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic open_row(input int r);
    addr = 9'(r); ras_n = 1'b0; step();
  endtask

  task automatic close_row();
    idle(); step();
  endtask

  // Early write of one column with given active-low lane mask; updates the model
  task automatic wr(input int r, input int c, input logic [1:0] ln, input logic [15:0] d);
    addr = 9'(c); dq_in = d; we_n = 1'b0; cas_n = ln; step();
    cas_n = 2'b11; step();
    we_n = 1'b1;
    if (!ln[0]) model[(r%8)*8 + (c%8)][7:0]  = d[7:0];
    if (!ln[1]) model[(r%8)*8 + (c%8)][15:8] = d[15:8];
  endtask

  // Read one column and check enables and driven lanes
  task automatic rd_chk(input string tag, input int r, input int c,
                        input logic [1:0] ln, input logic oe);
    logic [15:0] exp_w;
    logic [1:0]  exp_en;
    addr = 9'(c); we_n = 1'b1; oe_n = oe; cas_n = ln; step();
    exp_w  = model[(r%8)*8 + (c%8)];
    exp_en = ~ln & {2{~oe}};
    chk({tag, " oe"}, {14'd0, dq_oe}, {14'd0, exp_en});
    if (exp_en[0]) chk({tag, " lo"}, {8'd0, dq_out[7:0]},  {8'd0, exp_w[7:0]});
    if (exp_en[1]) chk({tag, " hi"}, {8'd0, dq_out[15:8]}, {8'd0, exp_w[15:8]});
    cas_n = 2'b11; oe_n = 1'b1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); addr = '0; dq_in = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1: reset/standby state
    chk("R1 reset oe", {14'd0, dq_oe}, 16'd0);
    chk("R1 reset err", {15'd0, proto_err}, 16'd0);

    // R8 R4: fill all 64 words by page-mode early writes
    for (int r = 0; r < 8; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) wr(r, c, 2'b00, pat(r, c));
      close_row();
    end
    chk("R1 standby after writes", {14'd0, dq_oe}, 16'd0);

    // R3 R8: sweep reads with rotating lane masks
    for (int r = 0; r < 8; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) begin
        logic [1:0] ln;
        ln = (c % 3 == 0) ? 2'b00 : (c % 3 == 1) ? 2'b10 : 2'b01;
        rd_chk("R3 R8 sweep", r, c, ln, 1'b0);
      end
      close_row();
    end

    // R4: upper-lane-only writes on row 2, lower lane preserved
    open_row(2);
    for (int c = 0; c < 8; c++) wr(2, c, 2'b01, {8'(c * 17 + 1), 8'hEE});
    for (int c = 0; c < 8; c++) rd_chk("R4 byte write", 2, c, 2'b00, 1'b0);
    close_row();

    // R4: late write on row 4 col 1 (WE falls after CAS)
    open_row(4);
    addr = 9'd1; cas_n = 2'b00; step();
    dq_in = 16'hC3A1; we_n = 1'b0; step();
    cas_n = 2'b11; step(); we_n = 1'b1;
    model[4*8+1] = 16'hC3A1;
    rd_chk("R4 late write", 4, 1, 2'b00, 1'b0);
    // R4: lane-staggered early write on col 2: lower then upper strobe
    addr = 9'd2; we_n = 1'b0; dq_in = 16'h1177; cas_n = 2'b10; step();
    addr = 9'd6; dq_in = 16'h88BB; cas_n = 2'b00; step();
    cas_n = 2'b11; step(); we_n = 1'b1;
    model[4*8+2] = 16'h8877;
    rd_chk("R4 staggered", 4, 2, 2'b00, 1'b0);
    rd_chk("R4 staggered col6 intact", 4, 6, 2'b00, 1'b0);
    close_row();

    // R2: combined column strobe
    open_row(1);
    addr = 9'd3; we_n = 1'b1; oe_n = 1'b0; cas_n = 2'b10; step();
    addr = 9'd5; cas_n = 2'b00; step();
    chk("R2 second fall oe", {14'd0, dq_oe}, 16'd3);
    chk("R2 second fall keeps col", dq_out, model[1*8+3]);
    addr = 9'd6; cas_n = 2'b01; step();
    chk("R2 one rises oe", {14'd0, dq_oe}, 16'd2);
    chk("R2 one rises keeps col", {8'd0, dq_out[15:8]}, {8'd0, model[1*8+3][15:8]});
    addr = 9'd5; cas_n = 2'b11; step();
    cas_n = 2'b01; step();
    chk("R2 new access col", {8'd0, dq_out[15:8]}, {8'd0, model[1*8+5][15:8]});
    // R7: OE withdrawn while strobe held
    oe_n = 1'b1; step();
    chk("R7 oe high mid read", {14'd0, dq_oe}, 16'd0);
    oe_n = 1'b0; we_n = 1'b0; step();
    chk("R7 we low floats", {14'd0, dq_oe}, 16'd0);
    cas_n = 2'b11; step(); we_n = 1'b1; oe_n = 1'b1;
    rd_chk("R7 oe high read", 1, 4, 2'b00, 1'b1);
    close_row();

    // R5: RAS-only refresh, outputs float, data kept
    addr = 9'd3; ras_n = 1'b0; oe_n = 1'b0; dq_in = 16'hDEAD; step(); step();
    chk("R5 ras-only float", {14'd0, dq_oe}, 16'd0);
    close_row();
    open_row(3);
    rd_chk("R5 data kept", 3, 0, 2'b00, 1'b0);
    close_row();

    // R6: CBR refresh, address ignored, no write, no error
    for (int k = 0; k < 3; k++) begin
      addr = 9'd0; cas_n = 2'b00; step();
      chk("R6 cbr setup no err", {15'd0, proto_err}, 16'd0);
      ras_n = 1'b0; step();
      we_n = 1'b0; oe_n = 1'b0; dq_in = 16'hBEEF; step();
      chk("R6 cbr float", {14'd0, dq_oe}, 16'd0);
      close_row();
    end
    open_row(0);
    rd_chk("R6 row0 col0 intact", 0, 0, 2'b00, 1'b0);
    close_row();

    // R11: row and column aliasing above the index bits
    open_row(9);
    rd_chk("R11 row alias", 1, 10, 2'b00, 1'b0);
    close_row();

    // R9: CAS fall with RAS high and WE low
    we_n = 1'b0; cas_n = 2'b10; step();
    chk("R9 err pulse", {15'd0, proto_err}, 16'd1);
    idle(); step();
    chk("R9 err clears", {15'd0, proto_err}, 16'd0);

    // R10: WE changes during early write
    open_row(6);
    addr = 9'd0; dq_in = pat(6, 0); we_n = 1'b0; cas_n = 2'b00; step();
    chk("R10 no err yet", {15'd0, proto_err}, 16'd0);
    we_n = 1'b1; step();
    chk("R10 err pulse", {15'd0, proto_err}, 16'd1);
    cas_n = 2'b11; step();
    chk("R10 err clears", {15'd0, proto_err}, 16'd0);
    close_row();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule